// File: doc/BRIEF.md
# Multiplexed Signed Decimal Display Driver

This block is the output stage of a small bus-based processor. When its load strobe is high at a rising clock edge it captures the byte currently on the bus. It then shows that byte as a decimal number on four time-shared 7-segment positions. The hundreds, tens and units of the magnitude are worked out combinationally from the captured byte whenever they are needed, so the block stores only the byte itself.

A mode input decides how the byte is read. With the mode low, the byte is an unsigned number from 0 to 255. With the mode high, the byte is a two's-complement number and the three decimal positions show its magnitude. In that mode the fourth position lights a minus sign when the number is negative.

A prescaler divides the clock, and a two-bit position counter steps through the four positions in a fixed order. Each position is held for the same number of cycles, and exactly one digit-select line is high at any time.

Top module: `seg_scan_display`

## Requirements
- R1: On a rising clock edge with `loadEn` high, the byte on `busIn` is captured. With `loadEn` low, the captured byte keeps its value whatever `busIn` does.
- R2: While `rstN` is low, the captured byte is zero and the scan sits on the units position. In that state `digitSel` is 4'b0001 and `segOut` shows the digit 0.
- R3: With `signedMode` low, the units, tens and hundreds positions show the decimal digits of the captured byte (0 to 255). Leading zeros are shown as the digit 0.
- R4: With `signedMode` high and bit 7 of the byte set, the three positions show 256 minus the byte's value. For example, 0x80 shows 128 and 0xFF shows 001. With bit 7 clear, they show the value itself.
- R5: The sign position drives `segOut` = 7'h40 (segment g only) when `signedMode` is high and bit 7 is set. In every other case it drives 7'h00 (blank).
- R6: `digitSel` is one-hot. Bit 0 selects units, bit 1 tens, bit 2 hundreds and bit 3 sign. The scan runs units, tens, hundreds, sign, then back to units.
- R7: Each position stays selected for exactly `SCAN_DIV` consecutive clock cycles. After reset is released, units is selected for the first `SCAN_DIV` cycles.
- R8: `segOut` is active high, with bit 0 = segment a through bit 6 = segment g. The digit patterns 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R9: A change of `signedMode` alters the displayed digits and sign in the same cycle, without a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busIn | input | 8 | Byte offered on the bus |
| loadEn | input | 1 | Capture strobe for `busIn` |
| signedMode | input | 1 | High: treat the byte as two's complement |
| segOut | output | 7 | Segment lines a..g, active high, bit 0 = a |
| digitSel | output | 4 | One-hot position select (units, tens, hundreds, sign) |

## Verification
The bench aims at the values where the binary-to-decimal conversion and the negation are easiest to get wrong: 0, 9, 10, 99, 100, 127, 0x80, 0x81, 0xFF, and the same byte read in both modes. A wrong add-3 threshold, or a negation that is off by one, would light the wrong digit patterns, and 0x80 in particular would fail to show 128. It also checks that a byte on the bus without the strobe leaves the display alone, and that flipping the mode alone moves both the digits and the minus sign. A wrong load path would show the new bus byte, and a latched mode would leave stale digits. Cycle-exact scan checks after reset catch a prescaler that holds positions for one cycle too many or too few, or that steps through the positions in the wrong order.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;

  localparam int DATA_W     = 8;
  localparam int MAG_DIGITS = 3;
  localparam int BCD_W      = 4 * MAG_DIGITS;
  localparam int NUM_POS    = MAG_DIGITS + 1;
  localparam int POS_W      = $clog2(NUM_POS);

  localparam logic [POS_W-1:0] POS_UNITS = POS_W'(0);
  localparam logic [POS_W-1:0] POS_TENS  = POS_W'(1);
  localparam logic [POS_W-1:0] POS_HUNS  = POS_W'(2);
  localparam logic [POS_W-1:0] POS_SIGN  = POS_W'(3);

  localparam logic [6:0] SEG_BLANK = 7'h00;
  localparam logic [6:0] SEG_MINUS = 7'h40;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             loadVal;
    logic [POS_W-1:0] scanPos;
  } disp_ctrl_t;

  // Shift-and-add-3 conversion of a binary value into packed BCD.
  function automatic logic [BCD_W-1:0] binToBcd(input logic [DATA_W-1:0] bin);
    logic [BCD_W+DATA_W-1:0] work;
    work = {{BCD_W{1'b0}}, bin};
    for (int s = 0; s < DATA_W; s++) begin
      for (int d = 0; d < MAG_DIGITS; d++) begin
        if (work[DATA_W+4*d +: 4] >= 4'd5)
          work[DATA_W+4*d +: 4] = work[DATA_W+4*d +: 4] + 4'd3;
      end
      work = work << 1;
    end
    return work[DATA_W +: BCD_W];
  endfunction

  // Active-high segments, bit 0 = a .. bit 6 = g.
  function automatic logic [6:0] segOf(input logic [3:0] dig);
    logic [6:0] pat;
    case (dig)
      4'd0:    pat = 7'h3F;
      4'd1:    pat = 7'h06;
      4'd2:    pat = 7'h5B;
      4'd3:    pat = 7'h4F;
      4'd4:    pat = 7'h66;
      4'd5:    pat = 7'h6D;
      4'd6:    pat = 7'h7D;
      4'd7:    pat = 7'h07;
      4'd8:    pat = 7'h7F;
      4'd9:    pat = 7'h6F;
      default: pat = SEG_BLANK;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/seg_disp_ctrl.sv
module seg_disp_ctrl
  import seg_disp_pkg::*;
#(
  parameter int SCAN_DIV = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  output disp_ctrl_t ctrl
);

  localparam int CNT_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SCAN_DIV - 1);

  logic [CNT_W-1:0] prescaleCnt;
  logic [POS_W-1:0] scanPos;
  logic             stepPos;

  assign stepPos = (prescaleCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescaleCnt <= '0;
      scanPos     <= POS_UNITS;
    end else if (stepPos) begin
      prescaleCnt <= '0;
      scanPos     <= (scanPos == POS_SIGN) ? POS_UNITS : scanPos + POS_W'(1);
    end else begin
      prescaleCnt <= prescaleCnt + CNT_W'(1);
    end
  end

  assign ctrl.loadVal = loadEn;
  assign ctrl.scanPos = scanPos;

  // R7: the prescaler never leaves its range
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    32'(prescaleCnt) < SCAN_DIV);

  // R7: the position holds until the prescaler wraps
  p_pos_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stepPos |=> $stable(scanPos));

  // R6: the scan order is units, tens, hundreds, sign, units
  p_pos_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    stepPos |=> scanPos == POS_W'($past(scanPos) + POS_W'(1)));

endmodule

// File: rtl/seg_disp_dp.sv
module seg_disp_dp
  import seg_disp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  disp_ctrl_t        ctrl,
  input  logic [DATA_W-1:0] busIn,
  input  logic              signedMode,
  output logic [6:0]        segOut,
  output logic [NUM_POS-1:0] digitSel
);

  logic [DATA_W-1:0] valReg;
  logic              isNeg;
  logic [DATA_W-1:0] magVal;
  logic [BCD_W-1:0]  bcdVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      valReg <= '0;
    else if (ctrl.loadVal)
      valReg <= busIn;
  end

  // Sign and magnitude follow the live mode input.
  assign isNeg  = signedMode & valReg[DATA_W-1];
  assign magVal = isNeg ? DATA_W'(~valReg + DATA_W'(1)) : valReg;
  assign bcdVal = binToBcd(magVal);

  always_comb begin
    case (ctrl.scanPos)
      POS_UNITS: segOut = segOf(bcdVal[3:0]);
      POS_TENS:  segOut = segOf(bcdVal[7:4]);
      POS_HUNS:  segOut = segOf(bcdVal[11:8]);
      default:   segOut = isNeg ? SEG_MINUS : SEG_BLANK;
    endcase
  end

  for (genvar p = 0; p < NUM_POS; p++) begin : g_sel
    assign digitSel[p] = (ctrl.scanPos == POS_W'(p));
  end

  // R1: a strobed byte is captured
  p_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadVal |=> valReg == $past(busIn));

  // R1: without the strobe the byte is kept
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadVal |=> $stable(valReg));

  // R3: the decimal digits are valid and add up to the magnitude
  p_bcd_exact_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bcdVal[3:0] <= 4'd9) && (bcdVal[7:4] <= 4'd9) && (bcdVal[11:8] <= 4'd2) &&
    (10'(bcdVal[11:8]) * 10'd100 + 10'(bcdVal[7:4]) * 10'd10 + 10'(bcdVal[3:0])
      == 10'(magVal)));

  // R4: a negative value shows a magnitude from 1 to 128
  p_neg_mag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (signedMode && valReg[DATA_W-1]) |-> (magVal != '0) && (magVal <= DATA_W'(128)));

  // R5: the sign position is blank unless the value is signed and negative
  p_sign_blank_r5: assert property (@(posedge clk) disable iff (!rstN)
    (digitSel[NUM_POS-1] && !(signedMode && valReg[DATA_W-1])) |-> segOut == SEG_BLANK);

  // R6: exactly one position is selected
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(digitSel) == 1);

endmodule

// File: rtl/seg_scan_display.sv
module seg_scan_display
  import seg_disp_pkg::*;
#(
  parameter int SCAN_DIV = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busIn,
  input  logic       loadEn,
  input  logic       signedMode,
  output logic [6:0] segOut,
  output logic [3:0] digitSel
);

  disp_ctrl_t ctrlBus;

  seg_disp_ctrl #(.SCAN_DIV(SCAN_DIV)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .loadEn (loadEn),
    .ctrl   (ctrlBus)
  );

  seg_disp_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrlBus),
    .busIn      (busIn),
    .signedMode (signedMode),
    .segOut     (segOut),
    .digitSel   (digitSel)
  );

endmodule

// File: tb/sim_seg_scan_display.sv
`timescale 1ns/1ps
module sim_seg_scan_display;

  localparam int D = 3;
  localparam int NVEC = 15;

  // byte, mode, hundreds, tens, units, negative
  localparam int vecTab [NVEC][6] = '{
    '{8'h00, 0, 0, 0, 0, 0},
    '{8'hFF, 0, 2, 5, 5, 0},
    '{8'hFF, 1, 0, 0, 1, 1},
    '{8'h80, 1, 1, 2, 8, 1},
    '{8'h7F, 1, 1, 2, 7, 0},
    '{8'h64, 0, 1, 0, 0, 0},
    '{8'h09, 0, 0, 0, 9, 0},
    '{8'h0A, 1, 0, 1, 0, 0},
    '{8'hC8, 1, 0, 5, 6, 1},
    '{8'h63, 0, 0, 9, 9, 0},
    '{8'h81, 1, 1, 2, 7, 1},
    '{8'h90, 0, 1, 4, 4, 0},
    '{8'h90, 1, 1, 1, 2, 1},
    '{8'hEE, 0, 2, 3, 8, 0},
    '{8'hEE, 1, 0, 1, 8, 1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busIn = '0;
  logic       loadEn = 1'b0;
  logic       signedMode = 1'b0;
  logic [6:0] segOut;
  logic [3:0] digitSel;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  seg_scan_display #(.SCAN_DIV(D)) u0 (
    .clk(clk), .rstN(rstN), .busIn(busIn), .loadEn(loadEn),
    .signedMode(signedMode), .segOut(segOut), .digitSel(digitSel)
  );

  always #10 clk = ~clk;

  // R8 digit patterns
  function automatic logic [6:0] expSeg(input int dig);
    case (dig)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic loadByte(input logic [7:0] v, input logic m);
    @(negedge clk);
    busIn = v; signedMode = m; loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // Watch one full scan and check each cycle's segments (R3 R4 R5 R8).
  task automatic scanCheck(input string req, input int hun, input int ten,
                           input int uni, input int neg);
    for (int c = 0; c < 4 * D; c++) begin
      @(negedge clk);
      case (digitSel)
        4'b0001: check({req, " units"}, segOut, expSeg(uni));
        4'b0010: check({req, " tens"},  segOut, expSeg(ten));
        4'b0100: check({req, " hundreds"}, segOut, expSeg(hun));
        4'b1000: check({req, " sign"}, segOut, neg ? 7'h40 : 7'h00);
        default: check("R6 one-hot select", digitSel, 4'b0001);
      endcase
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    repeat (2) @(negedge clk);
    check("R2 reset select", digitSel, 4'b0001);
    check("R2 reset segments", segOut, 7'h3F);
    rstN = 1'b1;

    // Vector table: R3 R4 R5 R8
    for (int i = 0; i < NVEC; i++) begin
      loadByte(8'(vecTab[i][0]), vecTab[i][1] != 0);
      scanCheck(vecTab[i][1] != 0 ? "R4/R5 signed" : "R3 unsigned",
                vecTab[i][2], vecTab[i][3], vecTab[i][4], vecTab[i][5]);
    end

    // R1: bus changes without the strobe are ignored
    loadByte(8'h2A, 1'b0);
    @(negedge clk);
    busIn = 8'h99;
    scanCheck("R1 hold", 0, 4, 2, 0);

    // R9: the mode acts without a reload
    loadByte(8'hC8, 1'b0);
    scanCheck("R9 unsigned view", 2, 0, 0, 0);
    @(negedge clk);
    signedMode = 1'b1;
    scanCheck("R9 signed view", 0, 5, 6, 1);

    // R2: asynchronous reset in mid-run
    loadByte(8'hFF, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R2 mid-run select", digitSel, 4'b0001);
    check("R2 mid-run segments", segOut, 7'h3F);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R6 R7: exact position timing after reset release
    for (int k = 0; k < 8 * D; k++) begin
      check("R7 dwell / R6 order", digitSel, 4'b0001 << ((k / D) % 4));
      @(negedge clk);
      #1;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule